// File: doc/BRIEF.md
# Locked Read-Modify-Write Cycle Sequencer

This block sits between the processor and the system-bus master port. It turns a locked processor read into the first half of an indivisible bus read-modify-write cycle. The cycle stays open, with bus ownership held, until the processor's next access to the bus, which is issued as the closing write. While the cycle is open, processor accesses to local DRAM pass through and do not close it.

The same block arbitrates local DRAM between the processor and external bus masters. While an external master has a read-modify-write cycle in progress on local DRAM, the processor is locked out so that it cannot interleave with that cycle.

Addresses below the `DRAM_TOP` parameter decode as local DRAM. All other addresses go to the bus. A processor request is held on `cpu_req_i` until it completes. A bus access completes on `bus_done_i`. A DRAM access completes in the cycle it is granted.

Top module: `rmw_lock_seq`

## Requirements
- R1: After reset the sequencer is idle. No cycle is open, `bus_hold_o` is 0, `bus_cyc_o` is 0, and both error pulses are 0.
- R2: A locked read (`cpu_lock_i`=1, `cpu_we_i`=0) to a bus address in the idle state is issued with `bus_cyc_o`=2 (RMW read) and `bus_hold_o`=1. Its `bus_done_i` opens the cycle.
- R3: While a cycle is open, the next bus access is issued with `bus_cyc_o`=3 (RMW close). `bus_hold_o` stays 1 until that access's `bus_done_i`. The sequencer is idle from the following cycle.
- R4: While a cycle is open, processor accesses to local DRAM do not close it, and `bus_hold_o` stays 1.
- R5: A locked read to a local DRAM address does not start a cycle. It raises no `bus_req_o` and no `bus_hold_o`, and the next bus access is a plain one.
- R6: If the access that closes a cycle is a read, `close_err_o` pulses for one cycle, in the cycle after its `bus_done_i`. The cycle still ends.
- R7: A locked read that crosses a word boundary pulses `split_err_o` in the cycle after its `bus_done_i`. A crossing read is one where `addr[1:0] + cpu_size_i > 3`, with `cpu_size_i` holding the byte count minus one. The cycle still opens.
- R8: While `ext_rmw_i` is 1, `dram_cpu_gnt_o` is 0.
- R9: DRAM grants are never both 1. In a tie between `ext_req_i` and a local processor request, the external master is granted (default `EXT_FIRST`=1).
- R10: A bus access that is not part of a locked cycle is issued with `bus_cyc_o`=1 (single). In the idle state it has `bus_hold_o`=0.
- R11: `bus_req_o` is 1 only for a processor request whose address is at or above `DRAM_TOP`. Requests below it compete for DRAM instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor access request, held until completion |
| cpu_addr_i | input | AW (32) | Byte address of the access |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_lock_i | input | 1 | Access carries the lock indication |
| cpu_size_i | input | OFS_W (2) | Access byte count minus one |
| bus_done_i | input | 1 | Current bus access completes this cycle |
| ext_req_i | input | 1 | External master requests local DRAM |
| ext_rmw_i | input | 1 | External read-modify-write cycle on local DRAM in progress |
| bus_req_o | output | 1 | Issue current processor access on the bus |
| bus_cyc_o | output | 2 | Bus cycle type: 0 none, 1 single, 2 RMW read, 3 RMW close |
| bus_hold_o | output | 1 | Keep bus ownership |
| dram_cpu_gnt_o | output | 1 | Processor granted local DRAM |
| dram_ext_gnt_o | output | 1 | External master granted local DRAM |
| close_err_o | output | 1 | Pulse: cycle closed by a read |
| split_err_o | output | 1 | Pulse: locked read crossed a word boundary |

## Verification
The assertions check the following on every cycle:
- the DRAM grants are exclusive, and the processor is locked out during an external cycle;
- bus requests and processor grants never coincide;
- a completed RMW read opens the cycle, and an open cycle persists across non-bus cycles;
- a completed close ends the cycle, and a closing read is flagged.

Only the bench scenarios show the following, because they need a reference model across sequences:
- the exact cycle-type encoding for each mix of lock, direction and address;
- the crossing detection on each offset and size;
- that local and locked-local accesses leave an open cycle and the idle state untouched.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [1:0] {
    CYC_NONE   = 2'd0,
    CYC_SINGLE = 2'd1,
    CYC_RMW_RD = 2'd2,
    CYC_RMW_WR = 2'd3
  } cyc_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_OPEN = 1'b1
  } st_e;
endpackage

// File: rtl/rmw_addr_dec.sv
module rmw_addr_dec #(
  parameter int unsigned AW         = 32,
  parameter logic [AW-1:0] DRAM_TOP = 32'h0100_0000,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned OFS_W     = $clog2(WORD_BYTES)
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [OFS_W-1:0] size_i,
  output logic             local_o,
  output logic             cross_o
);
  logic [OFS_W:0] end_ofs;

  assign local_o = addr_i < DRAM_TOP;
  // last byte offset past the word end
  assign end_ofs = {1'b0, addr_i[OFS_W-1:0]} + {1'b0, size_i};
  assign cross_o = end_ofs > (OFS_W+1)'(WORD_BYTES - 1);
endmodule

// File: rtl/rmw_fsm.sv
module rmw_fsm
  import rmw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_acc_i,
  input  logic lock_i,
  input  logic we_i,
  input  logic done_i,
  input  logic cross_i,
  output cyc_e cyc_o,
  output logic hold_o,
  output logic open_o,
  output logic close_err_o,
  output logic split_err_o
);
  st_e  st_q, st_d;
  logic lock_rd, close_now, open_now;

  assign lock_rd   = bus_acc_i && lock_i && !we_i;
  assign close_now = (st_q == ST_OPEN) && bus_acc_i && done_i;
  assign open_now  = (st_q == ST_IDLE) && lock_rd && done_i;

  always_comb begin
    st_d = st_q;
    if (close_now)     st_d = ST_IDLE;
    else if (open_now) st_d = ST_OPEN;
  end

  always_comb begin
    cyc_o = CYC_NONE;
    if (bus_acc_i) begin
      if (st_q == ST_OPEN) cyc_o = CYC_RMW_WR;
      else if (lock_rd)    cyc_o = CYC_RMW_RD;
      else                 cyc_o = CYC_SINGLE;
    end
  end

  assign open_o = (st_q == ST_OPEN);
  assign hold_o = open_o || lock_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      close_err_o <= 1'b0;
      split_err_o <= 1'b0;
    end else begin
      st_q        <= st_d;
      close_err_o <= close_now && !we_i;
      split_err_o <= open_now && cross_i;
    end
  end
endmodule

// File: rtl/rmw_dram_arb.sv
module rmw_dram_arb #(
  parameter bit EXT_FIRST = 1'b1
) (
  input  logic cpu_req_i,
  input  logic ext_req_i,
  input  logic ext_rmw_i,
  output logic cpu_gnt_o,
  output logic ext_gnt_o
);
  generate
    if (EXT_FIRST) begin : g_ext_first
      assign ext_gnt_o = ext_req_i;
      assign cpu_gnt_o = cpu_req_i && !ext_req_i && !ext_rmw_i;
    end else begin : g_cpu_first
      assign cpu_gnt_o = cpu_req_i && !ext_rmw_i;
      assign ext_gnt_o = ext_req_i && !cpu_gnt_o;
    end
  endgenerate
endmodule

// File: rtl/rmw_lock_seq.sv
module rmw_lock_seq
  import rmw_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter logic [AW-1:0] DRAM_TOP = 32'h0100_0000,
  parameter int unsigned WORD_BYTES = 4,
  parameter bit EXT_FIRST           = 1'b1,
  localparam int unsigned OFS_W     = $clog2(WORD_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_req_i,
  input  logic [AW-1:0]    cpu_addr_i,
  input  logic             cpu_we_i,
  input  logic             cpu_lock_i,
  input  logic [OFS_W-1:0] cpu_size_i,
  input  logic             bus_done_i,
  input  logic             ext_req_i,
  input  logic             ext_rmw_i,
  output logic             bus_req_o,
  output logic [1:0]       bus_cyc_o,
  output logic             bus_hold_o,
  output logic             dram_cpu_gnt_o,
  output logic             dram_ext_gnt_o,
  output logic             close_err_o,
  output logic             split_err_o
);
  logic is_local, is_cross, rmw_open;
  cyc_e cyc;

  rmw_addr_dec #(
    .AW(AW), .DRAM_TOP(DRAM_TOP), .WORD_BYTES(WORD_BYTES)
  ) u_dec (
    .addr_i (cpu_addr_i),
    .size_i (cpu_size_i),
    .local_o(is_local),
    .cross_o(is_cross)
  );

  assign bus_req_o = cpu_req_i && !is_local;

  rmw_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_acc_i  (bus_req_o),
    .lock_i     (cpu_lock_i),
    .we_i       (cpu_we_i),
    .done_i     (bus_done_i),
    .cross_i    (is_cross),
    .cyc_o      (cyc),
    .hold_o     (bus_hold_o),
    .open_o     (rmw_open),
    .close_err_o(close_err_o),
    .split_err_o(split_err_o)
  );

  assign bus_cyc_o = cyc;

  rmw_dram_arb #(.EXT_FIRST(EXT_FIRST)) u_arb (
    .cpu_req_i(cpu_req_i && is_local),
    .ext_req_i(ext_req_i),
    .ext_rmw_i(ext_rmw_i),
    .cpu_gnt_o(dram_cpu_gnt_o),
    .ext_gnt_o(dram_ext_gnt_o)
  );
endmodule

// File: rtl/rmw_lock_seq_chk.sv
module rmw_lock_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_req_o,
  input logic [1:0] bus_cyc_o,
  input logic       bus_done_i,
  input logic       cpu_we_i,
  input logic       rmw_open,
  input logic       close_err_o,
  input logic       ext_rmw_i,
  input logic       dram_cpu_gnt_o,
  input logic       dram_ext_gnt_o
);
  // R2
  rmw_rd_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_cyc_o == 2'd2 && bus_done_i |=> rmw_open);
  // R3
  close_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rmw_open && bus_req_o && bus_done_i |=> !rmw_open);
  // R4
  open_persists_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rmw_open && !bus_req_o |=> rmw_open);
  // R6
  close_rd_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_cyc_o == 2'd3 && bus_done_i && !cpu_we_i |=> close_err_o);
  // R8
  ext_lockout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rmw_i |-> !dram_cpu_gnt_o);
  // R9
  gnt_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dram_cpu_gnt_o && dram_ext_gnt_o));
  // R11
  bus_vs_dram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !dram_cpu_gnt_o);
endmodule

bind rmw_lock_seq rmw_lock_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_req_o     (bus_req_o),
  .bus_cyc_o     (bus_cyc_o),
  .bus_done_i    (bus_done_i),
  .cpu_we_i      (cpu_we_i),
  .rmw_open      (rmw_open),
  .close_err_o   (close_err_o),
  .ext_rmw_i     (ext_rmw_i),
  .dram_cpu_gnt_o(dram_cpu_gnt_o),
  .dram_ext_gnt_o(dram_ext_gnt_o)
);

// File: tb/rmw_lock_seq_tb.sv
module rmw_lock_seq_tb_top;
  localparam logic [31:0] TOP = 32'h0100_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, lock = 0, done = 0, ereq = 0, ermw = 0;
  logic [31:0] addr = '0;
  logic [1:0]  size = '0;
  logic bus_req, hold, cgnt, egnt, cerr, serr;
  logic [1:0] cyc;

  int total = 0, bad = 0;
  bit m_open = 0, m_cerr = 0, m_serr = 0, fin = 0;

  always #2.5 clk = ~clk;

  rmw_lock_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(req), .cpu_addr_i(addr),
    .cpu_we_i(we), .cpu_lock_i(lock), .cpu_size_i(size), .bus_done_i(done),
    .ext_req_i(ereq), .ext_rmw_i(ermw), .bus_req_o(bus_req), .bus_cyc_o(cyc),
    .bus_hold_o(hold), .dram_cpu_gnt_o(cgnt), .dram_ext_gnt_o(egnt),
    .close_err_o(cerr), .split_err_o(serr)
  );

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_cyc(bit bacc, bit opn, bit lk, bit w);
    if (!bacc) return 2'd0;
    if (opn) return 2'd3;
    if (lk && !w) return 2'd2;
    return 2'd1;
  endfunction

  function automatic bit crosses(logic [31:0] a, logic [1:0] s);
    return (32'(a[1:0]) + 32'(s)) > 3;
  endfunction

  // one cycle: drive, check comb outputs, advance model, check pulses
  task automatic step(bit r, logic [31:0] a, bit w, bit lk, logic [1:0] s,
                      bit d, bit er, bit em);
    bit bacc, lcl;
    @(negedge clk);
    req = r; addr = a; we = w; lock = lk; size = s; done = d; ereq = er; ermw = em;
    #1;
    lcl  = a < TOP;
    bacc = r && !lcl;
    check("R11 bus_req", bus_req, bacc);
    check(m_open ? "R3 cyc" : (lk ? "R2 cyc" : "R10 cyc"), cyc, exp_cyc(bacc, m_open, lk, w));
    check(m_open ? "R4 hold" : "R2 hold", hold, m_open || (bacc && lk && !w));
    check("R8 cpu_gnt", cgnt, r && lcl && !er && !em);
    check("R9 ext_gnt", egnt, er);
    m_cerr = 0; m_serr = 0;
    if (bacc && d) begin
      if (m_open) begin m_open = 0; m_cerr = !w; end
      else if (lk && !w) begin m_open = 1; m_serr = crosses(a, s); end
    end
    @(posedge clk);
    #1;
    check("R6 close_err", cerr, m_cerr);
    check("R7 split_err", serr, m_serr);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!fin) begin
      bad++;
      total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    check("R1 hold", hold, 0);
    check("R1 close_err", cerr, 0);
    check("R1 split_err", serr, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 check("R1 cyc", cyc, 0);
    // R10 plain bus read, idle
    step(1, TOP + 32'h10, 0, 0, 0, 1, 0, 0);
    // R2 locked read waits, then opens
    step(1, TOP + 32'h20, 0, 1, 3, 0, 0, 0);
    step(1, TOP + 32'h20, 0, 1, 3, 1, 0, 0);
    // R4 local accesses keep it open
    step(1, 32'h100, 1, 0, 0, 0, 0, 0);
    step(1, 32'h104, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    // R3 closing write
    step(1, TOP + 32'h20, 1, 1, 3, 0, 0, 0);
    step(1, TOP + 32'h20, 1, 1, 3, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    // R5 locked read to DRAM does not open
    step(1, 32'h40, 0, 1, 0, 0, 0, 0);
    step(1, TOP + 32'h44, 1, 0, 0, 1, 0, 0);
    // R6 closing read flags error
    step(1, TOP + 32'h80, 0, 1, 0, 1, 0, 0);
    step(1, TOP + 32'h80, 0, 0, 0, 1, 0, 0);
    // R7 crossing locked read, offset 2 size 3
    step(1, TOP + 32'h92, 0, 1, 2'd3, 1, 0, 0);
    step(1, TOP + 32'h92, 1, 1, 2'd3, 1, 0, 0);
    // R7 non-crossing boundary case, offset 1 size 2
    step(1, TOP + 32'h91, 0, 1, 2'd2, 1, 0, 0);
    step(1, TOP + 32'h91, 1, 0, 2'd2, 1, 0, 0);
    // R8 external RMW locks out DRAM
    step(1, 32'h200, 1, 0, 0, 0, 0, 1);
    step(1, 32'h200, 1, 0, 0, 0, 1, 1);
    // R9 tie goes to external master
    step(1, 32'h200, 1, 0, 0, 0, 1, 0);
    step(1, 32'h200, 1, 0, 0, 0, 0, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a;
      a = ($urandom % 2) ? ($urandom % TOP) : (TOP + ($urandom % 32'h1000));
      step(($urandom % 4) != 0, a, $urandom % 2, ($urandom % 3) == 0,
           2'($urandom), ($urandom % 3) != 0, ($urandom % 3) == 0,
           ($urandom % 5) == 0);
    end
    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule